// File: doc/BRIEF.md
# Parallel Response Collector for Command-Line Devices

After a shared command has gone out to a group of devices, this block collects each device's reply. Every device has its own single-wire command line, and each line is watched separately. A command-end pulse starts a latency counter for each enabled device. The first low level seen inside the permitted window is taken as that device's start bit. From then on, the lane for that device shifts in a 48-bit reply frame, runs a CRC over it and checks its framing bits. If a device stays silent until the window closes, its lane records a timeout. Devices finish at different times, so the group's exchange time is set by the slowest one.

The frame is sent MSB first and is laid out as follows:
- bit 47: start bit, 0
- bit 46: direction bit, 0 for a reply
- bits 45..40: 6-bit index
- bits 39..8: 32-bit argument
- bits 7..1: 7-bit CRC, generator x^7 + x^3 + 1, computed over bits 47..8 with a zero initial value
- bit 0: stop bit, 1

The results are plain held registers, not a stream. There is no back-pressure. The outputs of every lane stay unchanged from the moment that lane finishes until the next command-end pulse. A single-cycle completion pulse tells the controller when the whole group can be read.

Top module: `resp_collector`

## Requirements
- R1: A high `cmd_end` sampled on a clock edge clears all per-device results and `all_done`, latches `dev_en` as the group mask, and restarts latency counting at cycle 0. The edge sampling `cmd_end` is cycle 0, and the k-th following edge is cycle k.
- R2: A low on `cmd_line[i]` is accepted as the start bit only in cycles LAT_MIN..LAT_MAX (2..64). A low in cycle 1 is ignored, and the lane keeps waiting.
- R3: `resp_latency[i]` reports the cycle in which the start bit was accepted.
- R4: A device with no start bit by cycle LAT_MAX sets `dev_timeout[i]` and `dev_done[i]` at that edge. Its latency, index, argument and error flags all read 0.
- R5: After the start bit, 47 further bits are sampled, one per cycle. `dev_done[i]` rises on the edge that samples the stop bit. `resp_index[i]` holds frame bits 45..40 and `resp_arg[i]` holds frame bits 39..8.
- R6: `crc_err[i]` is 1 when frame bits 7..1 differ from the CRC computed over bits 47..8.
- R7: `end_err[i]` is 1 when frame bit 0 is 0.
- R8: `tx_err[i]` is 1 when frame bit 46 is 1.
- R9: A device masked off at `cmd_end` never sets `dev_done` or any status bit, whatever its line does. It also does not delay completion.
- R10: `all_done` is a one-cycle pulse. It comes one edge after the last masked-in device finishes, or on cycle 1 if the mask is empty, and appears exactly once per command.
- R11: Once finished, a lane's outputs hold their values, regardless of line activity, until the next `cmd_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_end | input | 1 | One-cycle pulse marking the end of the shared command |
| dev_en | input | N_DEV | Device enable mask, sampled with cmd_end |
| cmd_line | input | N_DEV | Per-device command line, idle high |
| all_done | output | 1 | One-cycle group completion pulse |
| dev_done | output | N_DEV | Lane finished (reply captured or timed out) |
| dev_timeout | output | N_DEV | No start bit inside the window |
| crc_err | output | N_DEV | CRC mismatch |
| end_err | output | N_DEV | Stop bit was 0 |
| tx_err | output | N_DEV | Direction bit was 1 |
| resp_index | output | 6*N_DEV | Captured index, lane i at bits 6i+5..6i |
| resp_arg | output | 32*N_DEV | Captured argument, lane i at bits 32i+31..32i |
| resp_latency | output | LAT_W*N_DEV | Start-bit cycle, lane i at bits LAT_W*i+LAT_W-1..LAT_W*i |

## Verification
The bench builds the block with its default values N_DEV=4, LAT_MIN=2 and LAT_MAX=64. With these values, both edges of the latency window can be reached directly, as can the first cycle beyond it, where a timeout occurs. Four lanes are enough to try mixed enable masks, including an empty one, and to produce groups in which a late, a timed-out and a corrupted reply all end up deciding the completion cycle. Because 7-bit latencies and 48-cycle frames are short, each exchange takes about 115 cycles, so random stimulus gives many exchanges within the budget.

// File: rtl/resp_pkg.sv
package resp_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam int FRAME_W   = 48;
  localparam int COVER_W   = FRAME_W - CRC_W - 1;   // bits under the CRC
  localparam int BIT_W     = $clog2(FRAME_W + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;   // x^7 + x^3 + 1

  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_WAIT = 2'd1,
    LN_RECV = 2'd2,
    LN_DONE = 2'd3
  } lane_state_e;
endpackage

// File: rtl/resp_crc7.sv
module resp_crc7
  import resp_pkg::*;
(
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic fb;
  always_comb begin
    fb    = bit_i ^ crc_i[CRC_W-1];
    crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/resp_lane.sv
module resp_lane
  import resp_pkg::*;
#(
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 64,
  localparam int LAT_W  = $clog2(LAT_MAX + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_end,
  input  logic             en,
  input  logic             line,
  output logic             fin,
  output logic             done,
  output logic             timeout,
  output logic             crc_err,
  output logic             end_err,
  output logic             tx_err,
  output logic [IDX_W-1:0] index,
  output logic [ARG_W-1:0] arg,
  output logic [LAT_W-1:0] latency
);
  lane_state_e        st;
  logic               active;
  logic [LAT_W-1:0]   cnt;
  logic [LAT_W-1:0]   cnt_nx;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-3:0] shreg;     // last 46 bits seen
  logic [CRC_W-1:0]   crc;
  logic [CRC_W-1:0]   crc_nx;

  resp_crc7 u_crc (.crc_i(crc), .bit_i(line), .crc_o(crc_nx));

  assign cnt_nx = cnt + 1'b1;
  assign fin    = done | ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= LN_IDLE; active <= 1'b0; cnt <= '0; bitn <= '0;
      shreg <= '0; crc <= '0; done <= 1'b0; timeout <= 1'b0;
      crc_err <= 1'b0; end_err <= 1'b0; tx_err <= 1'b0;
      index <= '0; arg <= '0; latency <= '0;
    end else if (cmd_end) begin
      st <= en ? LN_WAIT : LN_IDLE;
      active <= en; cnt <= '0; bitn <= '0; shreg <= '0; crc <= '0;
      done <= 1'b0; timeout <= 1'b0; crc_err <= 1'b0; end_err <= 1'b0;
      tx_err <= 1'b0; index <= '0; arg <= '0; latency <= '0;
    end else begin
      unique case (st)
        LN_WAIT: begin
          cnt <= cnt_nx;
          if (!line && cnt_nx >= LAT_W'(LAT_MIN)) begin
            st      <= LN_RECV;
            latency <= cnt_nx;
            shreg   <= {shreg[FRAME_W-4:0], line};
            crc     <= crc_nx;
            bitn    <= BIT_W'(1);
          end else if (cnt_nx == LAT_W'(LAT_MAX)) begin
            st      <= LN_DONE;
            timeout <= 1'b1;
            done    <= 1'b1;
          end
        end
        LN_RECV: begin
          bitn <= bitn + 1'b1;
          if (bitn < BIT_W'(COVER_W)) crc <= crc_nx;
          if (bitn == BIT_W'(FRAME_W - 1)) begin
            // shreg now holds frame bits 46..1, line is bit 0
            st      <= LN_DONE;
            done    <= 1'b1;
            tx_err  <= shreg[FRAME_W-3];
            index   <= shreg[FRAME_W-4 -: IDX_W];
            arg     <= shreg[CRC_W+ARG_W-1 -: ARG_W];
            crc_err <= (shreg[CRC_W-1:0] != crc);
            end_err <= ~line;
          end else begin
            shreg <= {shreg[FRAME_W-4:0], line};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/resp_join.sv
module resp_join #(
  parameter int N_DEV = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_end,
  input  logic [N_DEV-1:0] fin,
  output logic             all_done
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; all_done <= 1'b0;
    end else if (cmd_end) begin
      armed <= 1'b1; all_done <= 1'b0;
    end else if (armed && (&fin)) begin
      armed <= 1'b0; all_done <= 1'b1;
    end else begin
      all_done <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_collector.sv
module resp_collector
  import resp_pkg::*;
#(
  parameter int N_DEV   = 4,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 64,
  localparam int LAT_W  = $clog2(LAT_MAX + 1)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_end,
  input  logic [N_DEV-1:0]       dev_en,
  input  logic [N_DEV-1:0]       cmd_line,
  output logic                   all_done,
  output logic [N_DEV-1:0]       dev_done,
  output logic [N_DEV-1:0]       dev_timeout,
  output logic [N_DEV-1:0]       crc_err,
  output logic [N_DEV-1:0]       end_err,
  output logic [N_DEV-1:0]       tx_err,
  output logic [N_DEV*IDX_W-1:0] resp_index,
  output logic [N_DEV*ARG_W-1:0] resp_arg,
  output logic [N_DEV*LAT_W-1:0] resp_latency
);
  logic [N_DEV-1:0] fin;

  for (genvar g = 0; g < N_DEV; g++) begin : g_lane
    resp_lane #(.LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_lane (
      .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end),
      .en(dev_en[g]), .line(cmd_line[g]), .fin(fin[g]),
      .done(dev_done[g]), .timeout(dev_timeout[g]),
      .crc_err(crc_err[g]), .end_err(end_err[g]), .tx_err(tx_err[g]),
      .index(resp_index[g*IDX_W +: IDX_W]),
      .arg(resp_arg[g*ARG_W +: ARG_W]),
      .latency(resp_latency[g*LAT_W +: LAT_W])
    );
  end

  resp_join #(.N_DEV(N_DEV)) u_join (
    .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .fin(fin), .all_done(all_done)
  );
endmodule

// File: rtl/resp_collector_chk.sv
module resp_collector_chk #(
  parameter int N_DEV   = 4,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 64,
  localparam int LAT_W  = $clog2(LAT_MAX + 1)
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_end,
  input logic [N_DEV-1:0]       dev_en,
  input logic                   all_done,
  input logic [N_DEV-1:0]       dev_done,
  input logic [N_DEV-1:0]       dev_timeout,
  input logic [N_DEV*LAT_W-1:0] resp_latency
);
  logic [N_DEV-1:0] mask;
  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (cmd_end) mask <= dev_en;
  end

  a_r1_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> (dev_done == '0 && dev_timeout == '0 && !all_done));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> !all_done);
  a_r10_group_finished: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> ((mask & ~dev_done) == '0));
  a_r9_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done & ~mask) == '0);
  a_r4_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_timeout & ~dev_done) == '0);

  for (genvar g = 0; g < N_DEV; g++) begin : g_chk
    a_r3_latency_window: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_done[g] && !dev_timeout[g]) |->
        (resp_latency[g*LAT_W +: LAT_W] >= LAT_W'(LAT_MIN) &&
         resp_latency[g*LAT_W +: LAT_W] <= LAT_W'(LAT_MAX)));
    a_r4_timeout_latency: assert property (@(posedge clk) disable iff (!rst_n)
      dev_timeout[g] |-> resp_latency[g*LAT_W +: LAT_W] == '0);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_done[g] && !cmd_end) |=>
        (dev_done[g] && $stable(resp_latency[g*LAT_W +: LAT_W])));
  end
endmodule

bind resp_collector resp_collector_chk #(
  .N_DEV(N_DEV), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .dev_en(dev_en),
  .all_done(all_done), .dev_done(dev_done), .dev_timeout(dev_timeout),
  .resp_latency(resp_latency)
);

// File: tb/tb_resp_collector.sv
module tb_resp_collector;
  localparam int N = 4;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_end = 1'b0;
  logic [N-1:0] dev_en = '0;
  logic [N-1:0] cmd_line = '1;
  logic all_done;
  logic [N-1:0] dev_done, dev_timeout, crc_err, end_err, tx_err;
  logic [N*6-1:0] resp_index;
  logic [N*32-1:0] resp_arg;
  logic [N*LW-1:0] resp_latency;

  always #4 clk = ~clk;   // 125 MHz

  resp_collector dut (
    .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .dev_en(dev_en),
    .cmd_line(cmd_line), .all_done(all_done), .dev_done(dev_done),
    .dev_timeout(dev_timeout), .crc_err(crc_err), .end_err(end_err),
    .tx_err(tx_err), .resp_index(resp_index), .resp_arg(resp_arg),
    .resp_latency(resp_latency)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  int          lat  [N];
  logic [5:0]  idx  [N];
  logic [31:0] argv [N];
  bit          bcrc [N];
  bit          bend [N];
  bit          btx  [N];
  bit          glit [N];
  logic [47:0] fr   [N];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int b = 39; b >= 0; b--) begin
      logic fb = d[b] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_frame(input logic [5:0] ix, input logic [31:0] a,
                                           input bit ec, input bit ee, input bit et);
    logic [39:0] head = {1'b0, et, ix, a};
    return {head, crc7(head) ^ {6'd0, ec}, ~ee};
  endfunction

  task automatic exchange(input logic [N-1:0] en);
    int exp_d = 1;
    int seen = -1;
    int nseen = 0;
    for (int i = 0; i < N; i++) begin
      fr[i] = mk_frame(idx[i], argv[i], bcrc[i], bend[i], btx[i]);
      if (en[i]) exp_d = (lat[i] > 64) ? ((65 > exp_d) ? 65 : exp_d)
                                       : ((lat[i] + 48 > exp_d) ? lat[i] + 48 : exp_d);
    end
    @(negedge clk); dev_en = en; cmd_end = 1'b1;
    @(negedge clk); cmd_end = 1'b0;
    for (int k = 1; k <= 140; k++) begin
      for (int i = 0; i < N; i++) begin
        if (glit[i] && k == 1) cmd_line[i] = 1'b0;
        else if (lat[i] <= 64 && k >= lat[i] && k < lat[i] + 48)
          cmd_line[i] = fr[i][47 - (k - lat[i])];
        else cmd_line[i] = 1'b1;
      end
      @(negedge clk);
      if (all_done) begin nseen++; seen = k; end
    end
    cmd_line = '1;
    check("R10 all_done pulse count", 64'(nseen), 64'd1);
    check("R10 all_done cycle", 64'(seen), 64'(exp_d));
    for (int i = 0; i < N; i++) begin
      bit to = en[i] && lat[i] > 64;
      bit ok = en[i] && !to;
      if (!en[i]) check("R9 masked lane idle", {dev_done[i], dev_timeout[i], crc_err[i]}, 0);
      else        check("R5 lane done", 64'(dev_done[i]), 64'd1);
      check("R4 timeout flag", 64'(dev_timeout[i]), 64'(to));
      check("R3 latency", 64'(resp_latency[i*LW +: LW]), ok ? 64'(lat[i]) : 64'd0);
      check("R5 index", 64'(resp_index[i*6 +: 6]), ok ? 64'(idx[i]) : 64'd0);
      check("R5 argument", 64'(resp_arg[i*32 +: 32]), ok ? 64'(argv[i]) : 64'd0);
      check("R6 crc error", 64'(crc_err[i]), 64'(ok && bcrc[i]));
      check("R7 end error", 64'(end_err[i]), 64'(ok && bend[i]));
      check("R8 tx error", 64'(tx_err[i]), 64'(ok && btx[i]));
    end
  endtask

  task automatic hold_check();
    logic [N*LW-1:0] l0 = resp_latency;
    logic [N*32-1:0] a0 = resp_arg;
    logic [N-1:0] d0 = dev_done;
    logic [N-1:0] c0 = crc_err;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); cmd_line = N'($urandom);
    end
    @(negedge clk); cmd_line = '1;
    check("R11 hold latency", 64'(l0), 64'(resp_latency));
    check("R11 hold argument", a0[63:0], resp_arg[63:0]);
    check("R11 hold done", 64'(d0), 64'(dev_done));
    check("R11 hold crc flag", 64'(c0), 64'(crc_err));
  endtask

  task automatic clear_spec();
    for (int i = 0; i < N; i++) begin
      idx[i] = 6'($urandom); argv[i] = $urandom;
      bcrc[i] = 0; bend[i] = 0; btx[i] = 0; glit[i] = 0; lat[i] = 10;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset all_done", 64'(all_done), 64'd0);
    check("R1 reset done", 64'(dev_done), 64'd0);
    check("R1 reset index", resp_index[23:0], 0);
    check("R6 crc reference", 64'(crc7(40'h40_0000_0000)), 64'h4A);

    // window edges: 2, 64, and 65 (timeout)
    clear_spec();
    lat[0] = 2; lat[1] = 64; lat[2] = 65; lat[3] = 30;
    exchange(4'b1111);
    hold_check();

    // R2: cycle-1 low ignored
    clear_spec();
    glit[0] = 1; lat[0] = 5; glit[1] = 1; lat[1] = 2;
    exchange(4'b0011);

    // R9/R10: empty mask
    clear_spec();
    lat = '{3, 4, 5, 6};
    exchange(4'b0000);

    // R6/R7/R8 single errors, masked lane still active on its line
    clear_spec();
    bcrc[0] = 1; bend[1] = 1; btx[2] = 1; lat = '{7, 20, 40, 3};
    exchange(4'b0111);

    // R1: restart after results; all timeouts
    clear_spec();
    lat = '{70, 66, 65, 80};
    exchange(4'b1010);

    for (int t = 0; t < 40; t++) begin
      clear_spec();
      for (int i = 0; i < N; i++) begin
        lat[i]  = 2 + int'($urandom_range(0, 68));
        bcrc[i] = ($urandom_range(0, 7) == 0);
        bend[i] = ($urandom_range(0, 7) == 0);
        btx[i]  = ($urandom_range(0, 7) == 0);
        glit[i] = ($urandom_range(0, 5) == 0);
      end
      exchange(N'($urandom));
      if (t % 10 == 0) hold_check();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule